// File: doc/BRIEF.md
# Indirect-Access Address Table

This block holds a table of lookup entries, each 69 bits wide. The number of entries is set by a parameter. Software cannot reach the storage directly. It works through a window of four 32-bit registers: three data words that stage one entry, and one table-control word.

A single write to the control word names an index and carries a command bit. With the command bit clear, the indexed entry is copied into the staging words. With the command bit set, the staging words are committed to the indexed entry.

The staged entry is also decoded onto dedicated outputs: entry type, 48-bit MAC, multicast flag, VLAN ID and port number. Logic beside the table can observe these fields without going through the window.

Top module: `atbl_window`

## Requirements
- R1: The window registers are selected by `cfg_addr`:
  - 0 is data word 0, which holds entry bits 68:64 in its bits 4:0 and reads 0 in bits 31:5.
  - 1 is data word 1, which holds entry bits 63:32.
  - 2 is data word 2, which holds entry bits 31:0.
  - 3 is the control word.
- R2: A control write with bit 31 clear and an index (bits 30:0) below the depth loads that entry into the staging words. The new contents are readable from the cycle after the write.
- R3: A control write with bit 31 set and an in-range index stores the staging words into that entry. The staging words are left unchanged.
- R4: `stg_type` shows staged bits 61:60, with the encoding 0 free, 1 address, 2 VLAN, 3 VLAN plus address.
- R5: `stg_mac` shows staged bits 47:0, with MAC byte 0 in bits 47:40 and byte 5 in bits 7:0. `stg_mcast` shows bit 40, which is the low bit of byte 0.
- R6: `stg_vlan` shows staged bits 59:48, and `stg_port` shows staged bits 67:66.
- R7: A control write whose index is at or beyond the depth has the following effects:
  - With bit 31 set, it changes no entry.
  - With bit 31 clear, it loads all zeros.
  - The index never aliases onto a lower entry.
- R8: After reset, every entry reads back as all zeros, which is type free, and the staging words are zero.
- R9: A command is accepted in every cycle. A load issued in the cycle right after a store to the same index returns the stored value.
- R10: Reading the control word returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0..2 data words, 3 control) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| stg_type | output | 2 | Staged entry type |
| stg_mac | output | 48 | Staged MAC address |
| stg_mcast | output | 1 | Staged multicast flag |
| stg_vlan | output | 12 | Staged VLAN ID |
| stg_port | output | 2 | Staged port number |

## Verification
The bench targets the following corner cases:
- **Reversed word order.** A mirrored word map would return the low word at the top register and corrupt every decoded field.
- **Out-of-range indices.** An index of depth plus a small offset is stored and then loaded. A design that truncated the index would overwrite a live low entry.
- **Store then load on consecutive cycles.** A store immediately followed by a load of the same index exposes a table read that returns stale data.
- **Repeated stores.** Reading the staging words after a store catches a commit that clears or alters them.
- **Padding and reset.** Writing all ones to word 0 must read back only five bits. Loading untouched entries after reset must give type free, which catches an uninitialised table.

// File: rtl/atbl_pkg.sv
package atbl_pkg;
  localparam int WORD_W  = 32;
  localparam int CMD_BIT = 31;

  typedef enum logic [1:0] {
    ET_FREE      = 2'd0,
    ET_ADDR      = 2'd1,
    ET_VLAN      = 2'd2,
    ET_VLAN_ADDR = 2'd3
  } ent_type_e;

  typedef enum logic [1:0] {
    RS_WORD0 = 2'd0,
    RS_WORD1 = 2'd1,
    RS_WORD2 = 2'd2,
    RS_CTRL  = 2'd3
  } reg_sel_e;

  function automatic logic [30:0] ctl_index(input logic [31:0] w);
    return w[30:0];
  endfunction

  function automatic logic ctl_is_store(input logic [31:0] w);
    return w[CMD_BIT];
  endfunction

  function automatic logic [1:0] fld_type(input logic [63:0] lo);
    return lo[61:60];
  endfunction

  function automatic logic [47:0] fld_mac(input logic [63:0] lo);
    return lo[47:0];
  endfunction

  function automatic logic [11:0] fld_vlan(input logic [63:0] lo);
    return lo[59:48];
  endfunction
endpackage

// File: rtl/atbl_store.sv
module atbl_store #(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 69,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               st_en,
  input  logic [IDX_W-1:0]   st_idx,
  input  logic [ENTRY_W-1:0] st_data,
  input  logic [IDX_W-1:0]   ld_idx,
  output logic [ENTRY_W-1:0] ld_data
);
  logic [ENTRY_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]   live_q;

  always_ff @(posedge clk) begin
    if (st_en) mem_q[st_idx] <= st_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     live_q <= '0;
    else if (st_en) live_q[st_idx] <= 1'b1;
  end

  always_comb begin
    ld_data = live_q[ld_idx] ? mem_q[ld_idx] : '0;
  end
endmodule

// File: rtl/atbl_stage.sv
module atbl_stage #(
  parameter int ENTRY_W = 69,
  localparam int TOP_W  = ENTRY_W - 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         word_we,
  input  logic [31:0]        wdata,
  input  logic               ld_en,
  input  logic               ld_zero,
  input  logic [ENTRY_W-1:0] ld_data,
  output logic [ENTRY_W-1:0] stage_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (ld_en) begin
      stage_q <= ld_zero ? '0 : ld_data;
    end else begin
      if (word_we[0]) stage_q[ENTRY_W-1:64] <= wdata[TOP_W-1:0];
      if (word_we[1]) stage_q[63:32]        <= wdata;
      if (word_we[2]) stage_q[31:0]         <= wdata;
    end
  end
endmodule

// File: rtl/atbl_view.sv
module atbl_view
  import atbl_pkg::*;
#(
  parameter int ENTRY_W = 69
) (
  input  logic [ENTRY_W-1:0] stage,
  output logic [1:0]         v_type,
  output logic [47:0]        v_mac,
  output logic               v_mcast,
  output logic [11:0]        v_vlan,
  output logic [1:0]         v_port
);
  always_comb begin
    v_type  = fld_type(stage[63:0]);
    v_mac   = fld_mac(stage[63:0]);
    v_mcast = v_mac[40];
    v_vlan  = fld_vlan(stage[63:0]);
    v_port  = stage[67:66];
  end
endmodule

// File: rtl/atbl_window.sv
module atbl_window
  import atbl_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [1:0]  stg_type,
  output logic [47:0] stg_mac,
  output logic        stg_mcast,
  output logic [11:0] stg_vlan,
  output logic [1:0]  stg_port
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TOP_W = ENTRY_W - 64;

  logic               ctl_wr;
  logic               idx_ok;
  logic               ev_load;
  logic               ev_store;
  logic               ev_oob;
  logic [2:0]         word_we;
  logic [IDX_W-1:0]   idx;
  logic [31:0]        ctl_q;
  logic [ENTRY_W-1:0] stage_q;
  logic [ENTRY_W-1:0] rd_entry;

  always_comb begin
    ctl_wr   = cfg_wr && (cfg_addr == RS_CTRL);
    idx_ok   = {1'b0, ctl_index(cfg_wdata)} < 32'(DEPTH);
    idx      = cfg_wdata[IDX_W-1:0];
    ev_store = ctl_wr && ctl_is_store(cfg_wdata) && idx_ok;
    ev_load  = ctl_wr && !ctl_is_store(cfg_wdata);
    ev_oob   = ctl_wr && !idx_ok;
  end

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_we
      assign word_we[g] = cfg_wr && (cfg_addr == 2'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= cfg_wdata;
  end

  atbl_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_en   (ev_store),
    .st_idx  (idx),
    .st_data (stage_q),
    .ld_idx  (idx),
    .ld_data (rd_entry)
  );

  atbl_stage #(.ENTRY_W(ENTRY_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_we (word_we),
    .wdata   (cfg_wdata),
    .ld_en   (ev_load),
    .ld_zero (ev_oob),
    .ld_data (rd_entry),
    .stage_q (stage_q)
  );

  atbl_view #(.ENTRY_W(ENTRY_W)) u_view (
    .stage   (stage_q),
    .v_type  (stg_type),
    .v_mac   (stg_mac),
    .v_mcast (stg_mcast),
    .v_vlan  (stg_vlan),
    .v_port  (stg_port)
  );

  always_comb begin
    unique case (cfg_addr)
      RS_WORD0: cfg_rdata = {{(32-TOP_W){1'b0}}, stage_q[ENTRY_W-1:64]};
      RS_WORD1: cfg_rdata = stage_q[63:32];
      RS_WORD2: cfg_rdata = stage_q[31:0];
      default:  cfg_rdata = ctl_q;
    endcase
  end
endmodule

// File: rtl/atbl_window_chk.sv
module atbl_window_chk #(
  parameter int ENTRY_W = 69,
  localparam int TOP_W  = ENTRY_W - 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic [1:0]         cfg_addr,
  input logic [31:0]        cfg_wdata,
  input logic [31:0]        cfg_rdata,
  input logic               ev_load,
  input logic               ev_store,
  input logic               ev_oob,
  input logic [ENTRY_W-1:0] stage_q,
  input logic [31:0]        ctl_q,
  input logic [1:0]         stg_type,
  input logic [47:0]        stg_mac,
  input logic               stg_mcast
);
  a_r1_word0_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd0) |-> (cfg_rdata[31:TOP_W] == '0));

  a_r3_store_keeps_stage: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> $stable(stage_q));

  a_r5_mcast_bit: assert property (@(posedge clk) disable iff (!rst_n)
    stg_mcast == stg_mac[40]);

  a_r7_oob_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && ev_oob) |=> (stage_q == '0));

  a_r7_oob_load_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && ev_oob) |=> (stg_type == 2'd0));

  a_r10_ctl_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == 2'd3) |=> (ctl_q == $past(cfg_wdata)));
endmodule

bind atbl_window atbl_window_chk #(.ENTRY_W(ENTRY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .ev_load   (ev_load),
  .ev_store  (ev_store),
  .ev_oob    (ev_oob),
  .stage_q   (stage_q),
  .ctl_q     (ctl_q),
  .stg_type  (stg_type),
  .stg_mac   (stg_mac),
  .stg_mcast (stg_mcast)
);

// File: tb/test_atbl_window.sv
module test_atbl_window;
  localparam int DEPTH = 64;
  localparam int EW    = 69;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  stg_type;
  logic [47:0] stg_mac;
  logic        stg_mcast;
  logic [11:0] stg_vlan;
  logic [1:0]  stg_port;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [EW-1:0] mdl [DEPTH];
  logic [EW-1:0] cur;

  always #4 clk = ~clk;

  atbl_window #(.DEPTH(DEPTH), .ENTRY_W(EW)) i_atbl_window (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stg_type(stg_type),
    .stg_mac(stg_mac), .stg_mcast(stg_mcast), .stg_vlan(stg_vlan),
    .stg_port(stg_port)
  );

  function automatic logic [31:0] word_of(input logic [EW-1:0] e, input int w);
    case (w)
      0:       return {27'd0, e[68:64]};
      1:       return e[63:32];
      default: return e[31:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic stage_entry(input logic [EW-1:0] e);
    wr(2'd0, word_of(e, 0));
    wr(2'd1, word_of(e, 1));
    wr(2'd2, word_of(e, 2));
    cur = e;
  endtask

  task automatic store(input int idx);
    wr(2'd3, {1'b1, 31'(idx)});
    if (idx < DEPTH) mdl[idx] = cur;
  endtask

  task automatic load(input int idx);
    wr(2'd3, {1'b0, 31'(idx)});
    cur = (idx < DEPTH) ? mdl[idx] : '0;
  endtask

  task automatic check_stage(input string req);
    logic [31:0] d;
    for (int w = 0; w < 3; w++) begin
      rd(2'(w), d);
      check(req, 96'(d), 96'(word_of(cur, w)));
    end
  endtask

  task automatic check_views(input string req);
    @(negedge clk);
    #1;
    check({req, " R4 type"},  96'(stg_type),  96'(cur[61:60]));
    check({req, " R5 mac"},   96'(stg_mac),   96'(cur[47:0]));
    check({req, " R5 mcast"}, 96'(stg_mcast), 96'(cur[40]));
    check({req, " R6 vlan"},  96'(stg_vlan),  96'(cur[59:48]));
    check({req, " R6 port"},  96'(stg_port),  96'(cur[67:66]));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0]   d;
    logic [EW-1:0] e;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    cur = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: staging words and control word are zero after reset
    check_stage("R8 reset words");
    rd(2'd3, d);
    check("R10 reset ctrl", 96'(d), 96'd0);

    // R8: untouched entry loads as free
    load(5);
    check_stage("R8 reset entry");
    check("R8 reset type", 96'(stg_type), 96'd0);

    // R1: word 0 keeps only 5 bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check("R1 word0 pad", 96'(d), 96'h1F);

    // R1 R2 R4 R5 R6: directed multicast entry
    e = {2'd2, 1'b1, 2'd3, 12'hABC, 48'h01005E0000FB};
    stage_entry(e);
    store(9);
    check_stage("R3 stage kept");
    stage_entry('0);
    load(9);
    check_stage("R2 R1 load layout");
    check_views("directed");

    // R7: out-of-range store does not alias onto low entry
    stage_entry({5'h1F, 64'hDEAD_BEEF_0123_4567});
    store(DEPTH + 9);
    store(DEPTH + 7);
    load(9);
    check_stage("R7 no alias");
    load(DEPTH + 9);
    check_stage("R7 oob load zero");
    load(7);
    check_stage("R7 oob store ignored");

    // R9: store followed by load on the next cycle
    stage_entry({5'h0A, 64'h1234_5678_9ABC_DEF0});
    store(10);
    load(10);
    check_stage("R9 store then load");
    load(9);
    load(10);
    check_stage("R9 back to back loads");

    // R10: control readback
    wr(2'd3, {1'b0, 31'(DEPTH + 3)});
    cur = '0;
    rd(2'd3, d);
    check("R10 ctrl readback", 96'(d), 96'({1'b0, 31'(DEPTH + 3)}));

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      int idx;
      op  = int'($urandom_range(0, 2));
      idx = int'($urandom_range(0, DEPTH + 15));
      if (op == 0) begin
        e = {$urandom, $urandom, $urandom};
        stage_entry(e);
        store(idx);
      end else begin
        load(idx);
        if (k % 8 == 0) check_views("random");
        else            check_stage("R2 random load");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule